// File: doc/BRIEF.md
# Three-Channel Match Timer with Cross-Domain Snapshot

This block is a timer unit that sits on a simple register bus. It holds several independent up-counters, three by default. The counters run on a functional clock that has no fixed phase or ratio to the bus clock. Each counter is compared against its own set of match values. A per-channel selection mask picks which of those comparators send the counter back to a per-channel reload value. Every comparator hit latches a sticky status bit in the bus domain. Any status bit whose interrupt enable is set drives that channel's interrupt line.

A running counter cannot be sampled safely from the bus clock. Software therefore asks for a copy instead. A write to the channel's capture register sends a toggle into the counter domain. The counter value is frozen into a holding register there, and an acknowledge toggle returns to the bus domain. That acknowledge moves the frozen value into a bus-side copy. A busy flag stays high for the whole round trip, and the bus-side copy stays unchanged until the next round trip completes.

All register writes take effect on the bus clock edge where `wr_en` is high. Read data appears on `rdata` one bus clock after the edge where `rd_en` is high, and it holds until the next read.

Top module: `tmr_match_unit`

## Requirements
- R1: After reset all registers read 0, all counters are 0, `irq` is low and no capture is busy.
- R2: Bit c of the run register (word 25) starts counter c when set. While the bit is clear, counter c keeps its value. Counters of other channels are not affected.
- R3: A write with bit 0 set to the capture register of channel c (word 26+c) sets busy bit c (word 29, bit c). Busy clears once the captured count is available at that same capture address. The captured value stays constant until the next completed capture. A write with bit 0 clear starts no capture.
- R4: While running, if the count equals match value k of its channel (word 1+3c+k) and bit k of that channel's reload-select register (word 13+c) is set, the next count is the channel's reload value (word 10+c). Otherwise the count rises by one and wraps modulo 2^CW.
- R5: With match 0 at all ones, reload 0 and select bit 0 set, the counter passes through every value and returns to 0.
- R6: Status bit k of channel c (word 16+c) is set when the running count equals match k. Writing 1 to bit k of the clear register (word 22+c) clears that bit. A set in the same cycle wins over the clear. Writes to the status word have no effect.
- R7: `irq[c]` is high one bus clock after any status bit of channel c is set whose bit in the interrupt-enable register (word 19+c) is also set. It goes low one bus clock after no such bit remains.
- R8: The clock-control word (word 0) stores and returns all 32 bits. The clear registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| fclk | input | 1 | Functional counter clock |
| frst | input | 1 | Synchronous active-high reset, counter domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| irq | output | NCH | Per-channel interrupt |

## Verification
On every cycle, the assertions check the following. A stopped counter stays frozen. A selected comparator hit loads the reload value. The bus copy of a capture changes only on a returning acknowledge. Busy drops only after such an acknowledge. A status bit falls only on a clear write. The bench scenarios cover what needs a full round trip across both clocks: the exact value a capture returns, the range a reloading counter stays inside, status and interrupt patterns after whole passes of the counter, wrap through zero, and channel isolation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word-address layout, derived from channel and comparator counts.
  function automatic int unsigned a_clk();
    return 0;
  endfunction
  function automatic int unsigned a_match();
    return 1;
  endfunction
  function automatic int unsigned a_pre(int unsigned nch, int unsigned ncmp);
    return 1 + nch * ncmp;
  endfunction
  function automatic int unsigned a_psel(int unsigned nch, int unsigned ncmp);
    return a_pre(nch, ncmp) + nch;
  endfunction
  function automatic int unsigned a_stat(int unsigned nch, int unsigned ncmp);
    return a_psel(nch, ncmp) + nch;
  endfunction
  function automatic int unsigned a_ie(int unsigned nch, int unsigned ncmp);
    return a_stat(nch, ncmp) + nch;
  endfunction
  function automatic int unsigned a_clr(int unsigned nch, int unsigned ncmp);
    return a_ie(nch, ncmp) + nch;
  endfunction
  function automatic int unsigned a_run(int unsigned nch, int unsigned ncmp);
    return a_clr(nch, ncmp) + nch;
  endfunction
  function automatic int unsigned a_cap(int unsigned nch, int unsigned ncmp);
    return a_run(nch, ncmp) + 1;
  endfunction
  function automatic int unsigned a_busy(int unsigned nch, int unsigned ncmp);
    return a_cap(nch, ncmp) + nch;
  endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int NCMP = 3,
  parameter int CW   = 32
) (
  input  logic                     fclk,
  input  logic                     frst,
  input  logic                     run,
  input  logic [NCMP-1:0][CW-1:0]  match,
  input  logic [CW-1:0]            reload,
  input  logic [NCMP-1:0]          rsel,
  input  logic                     req_s,
  output logic [CW-1:0]            cnt,
  output logic [NCMP-1:0]          evt_tgl,
  output logic [CW-1:0]            held,
  output logic                     ack_tgl
);
  logic [NCMP-1:0] hit;
  logic            req_d;

  always_comb begin
    for (int k = 0; k < NCMP; k++) hit[k] = run && (cnt == match[k]);
  end

  always_ff @(posedge fclk) begin
    if (frst) begin
      cnt     <= '0;
      evt_tgl <= '0;
      held    <= '0;
      ack_tgl <= 1'b0;
      req_d   <= 1'b0;
    end else begin
      req_d   <= req_s;
      evt_tgl <= evt_tgl ^ hit;
      if (run) cnt <= (|(hit & rsel)) ? reload : cnt + CW'(1);
      if (req_s != req_d) begin
        held    <= cnt;
        ack_tgl <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [NCH*NCMP-1:0]           evt_s,
  input  logic [NCH-1:0]                ack_s,
  input  logic [NCH-1:0][CW-1:0]        held_f,
  output logic [DW-1:0]                 rdata,
  output logic [NCH-1:0]                irq,
  output logic [NCH*NCMP-1:0][CW-1:0]   match_q,
  output logic [NCH-1:0][CW-1:0]        reload_q,
  output logic [NCH-1:0][NCMP-1:0]      rsel_q,
  output logic [NCH-1:0]                run_q,
  output logic [NCH-1:0]                req_tgl,
  output logic [NCH-1:0]                busy_q,
  output logic [NCH-1:0][CW-1:0]        copy_q,
  output logic [NCH-1:0][NCMP-1:0]      stat_q,
  output logic [NCH-1:0][NCMP-1:0]      clr_stb
);
  localparam int A_CLK   = a_clk();
  localparam int A_MATCH = a_match();
  localparam int A_PRE   = a_pre(NCH, NCMP);
  localparam int A_PSEL  = a_psel(NCH, NCMP);
  localparam int A_STAT  = a_stat(NCH, NCMP);
  localparam int A_IE    = a_ie(NCH, NCMP);
  localparam int A_CLR   = a_clr(NCH, NCMP);
  localparam int A_RUN   = a_run(NCH, NCMP);
  localparam int A_CAP   = a_cap(NCH, NCMP);
  localparam int A_BUSY  = a_busy(NCH, NCMP);

  logic [DW-1:0]              clkctl_q;
  logic [NCH-1:0][NCMP-1:0]   ie_q;
  logic [NCH*NCMP-1:0]        evt_d;
  logic [NCH-1:0]             ack_d;
  logic [NCH*NCMP-1:0]        evt_edge;
  logic [NCH-1:0]             ack_edge;
  logic [DW-1:0]              rd_mux;

  assign evt_edge = evt_s ^ evt_d;
  assign ack_edge = ack_s ^ ack_d;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NCMP; k++)
        clr_stb[c][k] = wr_en && (addr == AW'(A_CLR + c)) && wdata[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkctl_q <= '0;
      run_q    <= '0;
      match_q  <= '0;
      reload_q <= '0;
      rsel_q   <= '0;
      ie_q     <= '0;
      stat_q   <= '0;
      busy_q   <= '0;
      copy_q   <= '0;
      req_tgl  <= '0;
      irq      <= '0;
      evt_d    <= '0;
      ack_d    <= '0;
    end else begin
      evt_d <= evt_s;
      ack_d <= ack_s;
      if (wr_en && addr == AW'(A_CLK)) clkctl_q <= wdata;
      if (wr_en && addr == AW'(A_RUN)) run_q <= wdata[NCH-1:0];
      for (int i = 0; i < NCH*NCMP; i++)
        if (wr_en && addr == AW'(A_MATCH + i)) match_q[i] <= wdata[CW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && addr == AW'(A_PRE + c))  reload_q[c] <= wdata[CW-1:0];
        if (wr_en && addr == AW'(A_PSEL + c)) rsel_q[c]   <= wdata[NCMP-1:0];
        if (wr_en && addr == AW'(A_IE + c))   ie_q[c]     <= wdata[NCMP-1:0];
        for (int k = 0; k < NCMP; k++) begin
          if (evt_edge[c*NCMP + k])  stat_q[c][k] <= 1'b1;
          else if (clr_stb[c][k])    stat_q[c][k] <= 1'b0;
        end
        if (ack_edge[c]) begin
          copy_q[c] <= held_f[c];
          busy_q[c] <= 1'b0;
        end else if (wr_en && addr == AW'(A_CAP + c) && wdata[0] && !busy_q[c]) begin
          busy_q[c]  <= 1'b1;
          req_tgl[c] <= ~req_tgl[c];
        end
        irq[c] <= |(stat_q[c] & ie_q[c]);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(A_CLK))  rd_mux = clkctl_q;
    if (addr == AW'(A_RUN))  rd_mux = DW'(run_q);
    if (addr == AW'(A_BUSY)) rd_mux = DW'(busy_q);
    for (int i = 0; i < NCH*NCMP; i++)
      if (addr == AW'(A_MATCH + i)) rd_mux = DW'(match_q[i]);
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(A_PRE + c))  rd_mux = DW'(reload_q[c]);
      if (addr == AW'(A_PSEL + c)) rd_mux = DW'(rsel_q[c]);
      if (addr == AW'(A_STAT + c)) rd_mux = DW'(stat_q[c]);
      if (addr == AW'(A_IE + c))   rd_mux = DW'(ie_q[c]);
      if (addr == AW'(A_CAP + c))  rd_mux = DW'(copy_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fclk,
  input  logic           frst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq
);
  logic [NCH*NCMP-1:0][CW-1:0] match_q;
  logic [NCH-1:0][CW-1:0]      reload_q;
  logic [NCH-1:0][NCMP-1:0]    rsel_q;
  logic [NCH-1:0]              run_q, run_f;
  logic [NCH-1:0]              req_tgl, req_f;
  logic [NCH-1:0]              ack_tgl, ack_s;
  logic [NCH*NCMP-1:0]         evt_tgl, evt_s;
  logic [NCH-1:0][CW-1:0]      held_f, cnt_f, copy_b;
  logic [NCH-1:0]              busy_b;
  logic [NCH-1:0][NCMP-1:0]    stat_b, clr_b;

  tmr_regs #(.NCH(NCH), .NCMP(NCMP), .CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .evt_s(evt_s), .ack_s(ack_s), .held_f(held_f), .rdata(rdata), .irq(irq),
    .match_q(match_q), .reload_q(reload_q), .rsel_q(rsel_q), .run_q(run_q),
    .req_tgl(req_tgl), .busy_q(busy_b), .copy_q(copy_b), .stat_q(stat_b), .clr_stb(clr_b)
  );

  tmr_sync #(.W(NCH)) u_run_sync (.clk(fclk), .rst(frst), .d(run_q), .q(run_f));
  tmr_sync #(.W(NCH)) u_req_sync (.clk(fclk), .rst(frst), .d(req_tgl), .q(req_f));
  tmr_sync #(.W(NCH)) u_ack_sync (.clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s));
  tmr_sync #(.W(NCH*NCMP)) u_evt_sync (.clk(clk), .rst(rst), .d(evt_tgl), .q(evt_s));

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tmr_chan #(.NCMP(NCMP), .CW(CW)) u_chan (
      .fclk(fclk), .frst(frst), .run(run_f[c]),
      .match(match_q[c*NCMP +: NCMP]), .reload(reload_q[c]), .rsel(rsel_q[c]),
      .req_s(req_f[c]), .cnt(cnt_f[c]), .evt_tgl(evt_tgl[c*NCMP +: NCMP]),
      .held(held_f[c]), .ack_tgl(ack_tgl[c])
    );
  end
endmodule

// File: rtl/tmr_match_unit_chk.sv
module tmr_match_unit_chk #(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        fclk,
  input logic                        frst,
  input logic [NCH-1:0]              busy,
  input logic [NCH-1:0]              ack_s,
  input logic [NCH-1:0][CW-1:0]      copy,
  input logic [NCH-1:0][NCMP-1:0]    stat,
  input logic [NCH-1:0][NCMP-1:0]    clr,
  input logic [NCH-1:0]              run_f,
  input logic [NCH-1:0][CW-1:0]      cnt,
  input logic [NCH-1:0][CW-1:0]      reload,
  input logic [NCH*NCMP-1:0][CW-1:0] match,
  input logic [NCH-1:0][NCMP-1:0]    rsel
);
  logic [NCH-1:0] ack_seen;
  always_ff @(posedge clk) ack_seen <= rst ? '0 : ack_s;

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic [NCMP-1:0] sel_hit;
    always_comb begin
      for (int k = 0; k < NCMP; k++) sel_hit[k] = rsel[c][k] && (cnt[c] == match[c*NCMP + k]);
    end

    assert_busy_release_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[c]) |-> $past(ack_s[c] != ack_seen[c]));
    assert_copy_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (ack_s[c] == ack_seen[c]) |=> $stable(copy[c]));
    assert_stopped_hold_R2: assert property (@(posedge fclk) disable iff (frst)
      !run_f[c] |=> $stable(cnt[c]));
    assert_reload_R4: assert property (@(posedge fclk) disable iff (frst)
      (run_f[c] && |sel_hit) |=> (cnt[c] == $past(reload[c])));

    for (genvar k = 0; k < NCMP; k++) begin : g_k
      assert_stat_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(stat[c][k]) |-> $past(clr[c][k]));
    end
  end
endmodule

bind tmr_match_unit tmr_match_unit_chk #(.NCH(NCH), .NCMP(NCMP), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fclk(fclk), .frst(frst), .busy(busy_b), .ack_s(ack_s),
  .copy(copy_b), .stat(stat_b), .clr(clr_b), .run_f(run_f), .cnt(cnt_f),
  .reload(reload_q), .match(match_q), .rsel(rsel_q)
);

// File: tb/tmr_match_unit_tb.sv
module tmr_match_unit_tb;
  import tmr_pkg::*;
  localparam int CLK_PERIOD  = 10;
  localparam int FCLK_PERIOD = 34;
  localparam int NCH = 3, NCMP = 3, CW = 8, DW = 32, AW = 5;
  localparam int A_PRE  = a_pre(NCH, NCMP);
  localparam int A_PSEL = a_psel(NCH, NCMP);
  localparam int A_STAT = a_stat(NCH, NCMP);
  localparam int A_IE   = a_ie(NCH, NCMP);
  localparam int A_CLR  = a_clr(NCH, NCMP);
  localparam int A_RUN  = a_run(NCH, NCMP);
  localparam int A_CAP  = a_cap(NCH, NCMP);
  localparam int A_BUSY = a_busy(NCH, NCMP);

  logic clk = 0, fclk = 0, rst = 1, frst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(FCLK_PERIOD/2) fclk = ~fclk;

  tmr_match_unit #(.NCH(NCH), .NCMP(NCMP), .CW(CW), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .fclk(fclk), .frst(frst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic fwait(input int n);
    repeat (n) @(posedge fclk);
    @(negedge clk);
  endtask

  task automatic capture(input int c, output logic [31:0] v);
    logic [31:0] b;
    wr(A_CAP + c, 32'h1);
    for (int i = 0; i < 100; i++) begin
      rd(A_BUSY, b);
      if (b[c] == 1'b0) break;
    end
    rd(A_CAP + c, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (6) @(posedge fclk);
    @(negedge clk); rst = 0;
    @(posedge fclk); frst = 0;
    fwait(4);

    // R1: reset state
    rd(A_RUN, v);     chk("R1 run reg", v, 0);
    rd(A_STAT, v);    chk("R1 status", v, 0);
    rd(A_BUSY, v);    chk("R1 busy", v, 0);
    rd(1 + 3, v);     chk("R1 match", v, 0);
    chk("R1 irq", 32'(irq), 0);
    capture(0, v);    chk("R1 counter zero", v, 0);

    // R8: clock-control storage, clear reads zero
    wr(0, 32'hA5C3_5A3C); rd(0, v); chk("R8 clkctl", v, 32'hA5C3_5A3C);
    wr(A_CLR + 1, 32'h7); rd(A_CLR + 1, v); chk("R8 clear reads 0", v, 0);

    // R3: busy set on request, no request on bit0 clear
    wr(A_CAP + 1, 32'h0); rd(A_BUSY, v); chk("R3 no request", v, 0);
    wr(A_CAP + 2, 32'h1); rd(A_BUSY, v); chk("R3 busy set", v, 32'h4);
    fwait(12); rd(A_BUSY, v); chk("R3 busy released", v, 0);

    // R4/R2: reload onto itself pins the counter; per-channel sweep
    for (int c = 0; c < NCH; c++) begin
      int pv = 8'h80 + c * 7;
      wr(A_PRE + c, 32'(pv));
      wr(1 + c*NCMP, 32'(pv));
      wr(A_PSEL + c, 32'h1);
      wr(A_RUN, 32'(1 << c));
      fwait(300);
      wr(A_RUN, 32'h0);
      fwait(8);
      capture(c, v);  chk("R4 pinned reload", v, 32'(pv));
      capture(c, v2); chk("R3 repeat capture stopped", v2, 32'(pv));
      capture((c + 1) % NCH, v);
      chk("R2 other channel untouched", v, (c == NCH-1) ? 32'h80 : 32'h0);
    end

    // R4: comparator 1 selected instead of 0
    wr(1 + 1, 32'h33); wr(A_PRE, 32'h33); wr(A_PSEL, 32'h2);
    wr(A_RUN, 32'h1); fwait(300); wr(A_RUN, 32'h0); fwait(8);
    capture(0, v); chk("R4 comparator 1 reload", v, 32'h33);

    // R4/R6/R7: bounded range, status pattern, interrupts
    wr(A_PRE + 1, 32'h10); wr(1 + 3, 32'h20); wr(1 + 4, 32'h18); wr(1 + 5, 32'h30);
    wr(A_PSEL + 1, 32'h1); wr(A_IE + 1, 32'h2);
    wr(A_RUN, 32'h2); fwait(300); wr(A_RUN, 32'h0); fwait(8);
    wr(A_CLR + 1, 32'h7); rd(A_STAT + 1, v); chk("R6 clear all", v, 0);
    @(negedge clk); chk("R7 irq low after clear", 32'(irq), 0);
    wr(A_RUN, 32'h2); fwait(300); wr(A_RUN, 32'h0); fwait(8);
    rd(A_STAT + 1, v); chk("R6 in-range hits only", v, 32'h3);
    chk("R7 irq from enabled bit", 32'(irq), 32'h2);
    capture(1, v); chk("R4 within reload range", 32'(v >= 32'h10 && v <= 32'h20), 1);
    wr(A_STAT + 1, 32'h0); rd(A_STAT + 1, v); chk("R6 status write ignored", v, 32'h3);
    wr(A_CLR + 1, 32'h2); rd(A_STAT + 1, v); chk("R6 partial clear", v, 32'h1);
    @(negedge clk); chk("R7 irq drops", 32'(irq), 0);

    // R5: full-range wrap, reload 0 at all ones
    wr(A_PRE + 2, 32'h0); wr(1 + 6, 32'hFF); wr(1 + 7, 32'h00); wr(1 + 8, 32'h05);
    wr(A_PSEL + 2, 32'h1);
    wr(A_RUN, 32'h4); fwait(300); wr(A_RUN, 32'h0); fwait(8);
    wr(A_CLR + 2, 32'h7);
    wr(A_RUN, 32'h4); fwait(600); wr(A_RUN, 32'h0); fwait(8);
    rd(A_STAT + 2, v); chk("R5 full pass incl 0 and FF", v, 32'h7);
    wr(A_CLR + 2, 32'h7); wr(A_PSEL + 2, 32'h0);
    wr(A_RUN, 32'h4); fwait(600); wr(A_RUN, 32'h0); fwait(8);
    rd(A_STAT + 2, v); chk("R4 natural wrap", v, 32'h7);

    // R3: live captures of a running counter differ
    wr(A_PSEL, 32'h0); wr(A_RUN, 32'h1); fwait(6);
    capture(0, v); fwait(20); capture(0, v2);
    chk("R3 live capture advances", 32'(v != v2), 1);
    wr(A_RUN, 32'h0);

    finish_run();
  end
endmodule